// File: doc/BRIEF.md
# Ordered Successive Interference Canceller

This block resolves the hard decisions of a group of users that share one channel, given each user's signed decision statistic and a square matrix of signed cross-correlation coefficients. It resolves the users one per clock. Each cycle it picks the user whose current statistic has the largest magnitude among those not yet resolved, and decides that user's bit from the sign of the statistic. In the following cycle it removes that user's interference from every user still pending. The update of all pending lanes and the search for the next strongest user both complete in that same clock. A group of `N` users therefore takes `N` cycles. For QPSK, the in-phase and quadrature bits count as separate users.

Software-side logic or an upstream pipeline writes the statistics one at a time and the matrix one row at a time while the block is idle. It then pulses `start`. `busy` stays high for exactly `N` cycles. `done` then pulses and the decision vector is valid. The run overwrites the statistics in place, so they must be written again before the next run. The matrix is kept between runs.

Top module: `ordered_sic`

## Requirements
- R1: While `busy` is low, `stat_we` writes `stat_data` as the statistic of user `stat_idx`, and `row_we` writes `row_data` as matrix row `row_idx`. Coefficient C(row,k) is held at bits `[k*W +: W]`. While `busy` is high, both writes and `start` are ignored.
- R2: When `start` is sampled with `busy` low, `busy` is high from the next cycle. It stays high for exactly `N` cycles. When it falls, `done` is high for exactly one cycle.
- R3: Each busy cycle resolves exactly one user. That user is the one whose current statistic has the largest magnitude among the unresolved users. On equal magnitudes the lower user index wins. The value -2048 has magnitude 2048.
- R4: The decision bit is 1 when the selected statistic is negative (symbol -1) and 0 when it is zero or positive (symbol +1).
- R5: The first busy cycle cancels nothing. In each later busy cycle, every unresolved user k takes s_k − b·C(j,k), where j is the user resolved in the previous cycle and b = +1 for bit 0, −1 for bit 1.
- R6: The update saturates at the 12-bit two's-complement limits, 2047 and −2048, and does not wrap.
- R7: A resolved user's statistic is frozen for the rest of the run, and each user is resolved exactly once per run.
- R8: `dec_bits` reads all zero in the first busy cycle. It holds its final value from `done` until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stat_we | input | 1 | Write one statistic |
| stat_idx | input | IW | User index of the statistic write |
| stat_data | input | W | Signed statistic value |
| row_we | input | 1 | Write one matrix row |
| row_idx | input | IW | Row (interfering user) index |
| row_data | input | N*W | Signed coefficients of the row, user k at `[k*W +: W]` |
| start | input | 1 | Begin a detection run |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse when the run completes |
| dec_bits | output | N | Decision per user, 1 means symbol −1 |

## Verification
A wrong pick or a wrong tie-break changes which coefficients are subtracted. This flips the decisions of later users, visible in `dec_bits` at `done`, `N` cycles after `start`. The directed cases are built so that a reversed order, a reversed tie or a wrapping adder gives a different decision vector. A lane that stays unfrozen, or a matrix write that leaks in while busy, shows in the same decision vector of that run or of a later run that reuses the matrix. A counter that stops at the wrong count shows immediately as a `done` pulse at the wrong distance from `start`.

// File: rtl/sic_pkg.sv
// Package: shared definitions for the ordered interference canceller.
// Assumes nothing beyond IEEE 1800-2017.
package sic_pkg;

    // Run-state of the sequencing controller.
    typedef enum logic {
        RUN_IDLE = 1'b0,
        RUN_ACT  = 1'b1
    } run_state_e;

endpackage

// File: rtl/sic_ctrl.sv
// Module: sic_ctrl
// Sequences one detection run: accepts start while idle, stays busy for
// exactly N cycles, pulses done as busy falls. The first busy cycle is the
// search-only cycle (cancel_en low).
// Assumes: N >= 1; start while busy has no effect.
module sic_ctrl
    import sic_pkg::*;
#(
    parameter int N = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic go,
    output logic busy,
    output logic done,
    output logic upd_en,
    output logic cancel_en
);
    localparam int CW = $clog2(N + 1);

    run_state_e    state_q;
    logic [CW-1:0] cnt_q;
    logic          primed_q;

    // Start is accepted only while idle.
    assign go        = start && (state_q == RUN_IDLE);
    assign busy      = (state_q == RUN_ACT);
    assign upd_en    = busy;
    assign cancel_en = busy && primed_q;

    // Cycle counter and state progression of the run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= RUN_IDLE;
            cnt_q    <= '0;
            primed_q <= 1'b0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go) begin
                state_q  <= RUN_ACT;
                cnt_q    <= '0;
                primed_q <= 1'b0;
            end else if (state_q == RUN_ACT) begin
                primed_q <= 1'b1;
                cnt_q    <= cnt_q + 1'b1;
                if (cnt_q == CW'(N - 1)) begin
                    state_q <= RUN_IDLE;
                    done    <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/sic_lane.sv
// Module: sic_lane
// One user lane: holds the user's statistic and forms the candidate value
// (saturating add or subtract of the coefficient, steered by the sign of
// the bit being cancelled) and the candidate's magnitude.
// Assumes: coefficients and statistics are W-bit two's complement.
module sic_lane #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld_en,
    input  logic [W-1:0] ld_val,
    input  logic         upd_en,
    input  logic         cancel_en,
    input  logic         add_mode,
    input  logic         frozen,
    input  logic [W-1:0] coef,
    output logic [W-1:0] stat_q,
    output logic [W-1:0] cand,
    output logic [W-1:0] mag
);
    localparam logic signed [W:0] HI = {2'b00, {(W-1){1'b1}}};
    localparam logic signed [W:0] LO = {2'b11, {(W-1){1'b0}}};

    logic signed [W:0] ext_s;
    logic signed [W:0] ext_c;
    logic signed [W:0] raw;
    logic [W-1:0]      sat_v;

    // Widened add/subtract steered by the cancelled bit, then clamp.
    always_comb begin
        ext_s = {stat_q[W-1], stat_q};
        ext_c = {coef[W-1], coef};
        raw   = add_mode ? (ext_s + ext_c) : (ext_s - ext_c);
        if (raw > HI)      sat_v = HI[W-1:0];
        else if (raw < LO) sat_v = LO[W-1:0];
        else               sat_v = raw[W-1:0];
    end

    // Candidate only differs from the stored value when cancelling.
    assign cand = (cancel_en && !frozen) ? sat_v : stat_q;

    // Magnitude as W-bit unsigned; the most negative value maps to 2^(W-1).
    assign mag = cand[W-1] ? ((~cand) + {{(W-1){1'b0}}, 1'b1}) : cand;

    // Statistic register: external write when idle, update while pending.
    always_ff @(posedge clk) begin
        if (!rst_n)                 stat_q <= '0;
        else if (ld_en)             stat_q <= ld_val;
        else if (upd_en && !frozen) stat_q <= cand;
    end

endmodule

// File: rtl/sic_argmax.sv
// Module: sic_argmax
// Finds the eligible lane with the largest magnitude in one combinational
// pass. A later lane wins only when strictly larger, so ties go to the
// lowest index.
// Assumes: mag_flat packs lane k at [k*W +: W].
module sic_argmax #(
    parameter int N  = 8,
    parameter int W  = 12,
    parameter int IW = 3
) (
    input  logic [N*W-1:0] mag_flat,
    input  logic [N-1:0]   elig,
    output logic [IW-1:0]  win_idx,
    output logic           win_any
);
    logic [W-1:0] best_mag;

    // Linear priority scan over all lanes.
    always_comb begin
        win_idx  = '0;
        win_any  = 1'b0;
        best_mag = '0;
        for (int k = 0; k < N; k++) begin
            if (elig[k] && (!win_any || (mag_flat[k*W +: W] > best_mag))) begin
                win_any  = 1'b1;
                best_mag = mag_flat[k*W +: W];
                win_idx  = IW'(k);
            end
        end
    end

endmodule

// File: rtl/ordered_sic.sv
// Module: ordered_sic
// Top of the decision-ordered successive interference canceller. Resolves
// one user per clock: picks the strongest pending statistic, registers its
// sign as the decision, and cancels it from all pending lanes next cycle.
// Assumes: statistics are reloaded before each run; matrix persists.
module ordered_sic #(
    parameter  int N  = 8,
    parameter  int W  = 12,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           stat_we,
    input  logic [IW-1:0]  stat_idx,
    input  logic [W-1:0]   stat_data,
    input  logic           row_we,
    input  logic [IW-1:0]  row_idx,
    input  logic [N*W-1:0] row_data,
    input  logic           start,
    output logic           busy,
    output logic           done,
    output logic [N-1:0]   dec_bits
);
    logic           go;
    logic           upd_en;
    logic           cancel_en;
    logic [N*W-1:0] mat_q [N];
    logic [N-1:0]   det_q;
    logic [N-1:0]   dec_q;
    logic [IW-1:0]  sel_q;
    logic [IW-1:0]  win_idx;
    logic           win_any;
    logic           win_neg;
    logic [N*W-1:0] sel_row;
    logic [N*W-1:0] stat_flat;
    logic [N*W-1:0] cand_flat;
    logic [N*W-1:0] mag_flat;

    sic_ctrl #(.N(N)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .go        (go),
        .busy      (busy),
        .done      (done),
        .upd_en    (upd_en),
        .cancel_en (cancel_en)
    );

    // Matrix row storage, writable only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) mat_q[i] <= '0;
        end else if (row_we && !busy && (int'(row_idx) < N)) begin
            mat_q[row_idx] <= row_data;
        end
    end

    // Row of the user resolved in the previous cycle.
    assign sel_row = mat_q[sel_q];

    generate
        for (genvar k = 0; k < N; k++) begin : g_lane
            logic ld_k;
            assign ld_k = stat_we && !busy && (stat_idx == IW'(k));
            sic_lane #(.W(W)) u_lane (
                .clk       (clk),
                .rst_n     (rst_n),
                .ld_en     (ld_k),
                .ld_val    (stat_data),
                .upd_en    (upd_en),
                .cancel_en (cancel_en),
                .add_mode  (dec_q[sel_q]),
                .frozen    (det_q[k]),
                .coef      (sel_row[k*W +: W]),
                .stat_q    (stat_flat[k*W +: W]),
                .cand      (cand_flat[k*W +: W]),
                .mag       (mag_flat[k*W +: W])
            );
        end
    endgenerate

    sic_argmax #(.N(N), .W(W), .IW(IW)) u_pick (
        .mag_flat (mag_flat),
        .elig     (~det_q),
        .win_idx  (win_idx),
        .win_any  (win_any)
    );

    // Sign of the winning lane's candidate statistic.
    always_comb begin
        win_neg = 1'b0;
        for (int k = 0; k < N; k++) begin
            if (win_idx == IW'(k)) win_neg = cand_flat[k*W + W - 1];
        end
    end

    // Resolution flags, decisions and last selection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            det_q <= '0;
            dec_q <= '0;
            sel_q <= '0;
        end else if (go) begin
            det_q <= '0;
            dec_q <= '0;
            sel_q <= '0;
        end else if (upd_en && win_any) begin
            det_q[win_idx] <= 1'b1;
            dec_q[win_idx] <= win_neg;
            sel_q          <= win_idx;
        end
    end

    assign dec_bits = dec_q;

endmodule

// File: rtl/sic_checker.sv
// Module: sic_checker
// Property checks for ordered_sic, attached by bind below.
module sic_checker #(
    parameter int N  = 8,
    parameter int W  = 12,
    parameter int IW = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic           busy,
    input logic           done,
    input logic [N-1:0]   det,
    input logic [IW-1:0]  win_idx,
    input logic [N*W-1:0] mag_flat,
    input logic [N*W-1:0] stat_flat,
    input logic [N-1:0]   dec_bits
);
    assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_all_resolved_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (&det));

    assert_fresh_pick_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !det[win_idx]);

    assert_one_per_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($countones(det) == $countones($past(det)) + 1));

    assert_bits_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(dec_bits));

    generate
        for (genvar k = 0; k < N; k++) begin : g_frz
            assert_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (busy && det[k]) |=> $stable(stat_flat[k*W +: W]));
        end
    endgenerate

    // Magnitude ordering and tie-break of the pick, checked mid-cycle.
    always @(negedge clk) begin
        if (rst_n && busy) begin
            for (int k = 0; k < N; k++) begin
                if (!det[k] && (k != int'(win_idx))) begin
                    assert_max_pick_R3: assert (mag_flat[int'(win_idx)*W +: W] >= mag_flat[k*W +: W])
                        else $error("pick %0d weaker than lane %0d", win_idx, k);
                    if (k < int'(win_idx)) begin
                        assert_tie_low_R3: assert (mag_flat[int'(win_idx)*W +: W] > mag_flat[k*W +: W])
                            else $error("tie not given to lane %0d", k);
                    end
                end
            end
        end
    end

endmodule

bind ordered_sic sic_checker #(.N(N), .W(W), .IW(IW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .det       (det_q),
    .win_idx   (win_idx),
    .mag_flat  (mag_flat),
    .stat_flat (stat_flat),
    .dec_bits  (dec_bits)
);

// File: tb/ordered_sic_tb.sv
// Bench for ordered_sic: directed corner cases plus a random sweep, with a
// behavioural model of the sequential ordered-cancellation algorithm.
module ordered_sic_tb;
    localparam int N  = 8;
    localparam int W  = 12;
    localparam int IW = 3;
    localparam int HI = 2047;
    localparam int LO = -2048;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           stat_we = 1'b0;
    logic [IW-1:0]  stat_idx = '0;
    logic [W-1:0]   stat_data = '0;
    logic           row_we = 1'b0;
    logic [IW-1:0]  row_idx = '0;
    logic [N*W-1:0] row_data = '0;
    logic           start = 1'b0;
    logic           busy;
    logic           done;
    logic [N-1:0]   dec_bits;

    int checks = 0;
    int failures = 0;
    int cyc_total = 0;
    int st [N];
    int rm [N][N];

    ordered_sic #(.N(N), .W(W)) u_dut (
        .clk (clk), .rst_n (rst_n),
        .stat_we (stat_we), .stat_idx (stat_idx), .stat_data (stat_data),
        .row_we (row_we), .row_idx (row_idx), .row_data (row_data),
        .start (start), .busy (busy), .done (done), .dec_bits (dec_bits)
    );

    always #10 clk = ~clk;

    // Watchdog: an expired run counts as a failed check.
    always @(posedge clk) begin
        cyc_total++;
        if (cyc_total > 150000) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=%0d expected<=150000", cyc_total);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(input bit ok, input string what, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    function automatic int mag_of(input int v);
        return (v < 0) ? -v : v;
    endfunction

    // Sequential reference: pick strongest, decide sign, cancel, clamp.
    function automatic logic [N-1:0] model();
        int s [N];
        bit d [N];
        logic [N-1:0] eb = '0;
        for (int k = 0; k < N; k++) begin s[k] = st[k]; d[k] = 1'b0; end
        for (int step = 0; step < N; step++) begin
            int best = -1;
            int bv;
            for (int k = 0; k < N; k++)
                if (!d[k] && (best < 0 || mag_of(s[k]) > mag_of(s[best]))) best = k;
            d[best] = 1'b1;
            eb[best] = (s[best] < 0);
            bv = (s[best] < 0) ? -1 : 1;
            for (int k = 0; k < N; k++) begin
                if (!d[k]) begin
                    int v = s[k] - bv * rm[best][k];
                    if (v > HI) v = HI;
                    if (v < LO) v = LO;
                    s[k] = v;
                end
            end
        end
        return eb;
    endfunction

    task automatic load_stats();
        for (int k = 0; k < N; k++) begin
            @(negedge clk);
            stat_we = 1'b1; stat_idx = IW'(k); stat_data = st[k][W-1:0];
        end
        @(negedge clk);
        stat_we = 1'b0;
    endtask

    task automatic load_rows();
        for (int i = 0; i < N; i++) begin
            @(negedge clk);
            row_we = 1'b1; row_idx = IW'(i);
            for (int k = 0; k < N; k++) row_data[k*W +: W] = rm[i][k][W-1:0];
        end
        @(negedge clk);
        row_we = 1'b0;
    endtask

    task automatic clear_case();
        for (int i = 0; i < N; i++) begin
            st[i] = 0;
            for (int k = 0; k < N; k++) rm[i][k] = 0;
        end
    endtask

    // Start a run, check handshake timing and final decisions.
    task automatic run_check(input string tag, input logic [N-1:0] exp, input bit junk);
        int cyc = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        check(busy === 1'b1, {"R2 busy after start ", tag}, busy, 1);
        check(dec_bits === '0, {"R8 bits cleared ", tag}, dec_bits, 0);
        while (done !== 1'b1 && cyc < N + 4) begin
            if (junk) begin
                stat_we = 1'b1; stat_idx = IW'($urandom_range(N-1));
                stat_data = W'($urandom);
                row_we = 1'b1; row_idx = IW'($urandom_range(N-1));
                row_data = {N{W'($urandom)}};
                start = 1'b1;
            end
            @(negedge clk);
            cyc++;
        end
        stat_we = 1'b0; row_we = 1'b0; start = 1'b0;
        check(cyc == N, {"R2 run length ", tag}, cyc, N);
        check(busy === 1'b0, {"R2 idle at done ", tag}, busy, 0);
        check(dec_bits === exp, {"R3 R4 R5 decisions ", tag}, dec_bits, exp);
        @(negedge clk);
        check(done === 1'b0, {"R2 done one cycle ", tag}, done, 0);
        @(negedge clk);
        check(dec_bits === exp, {"R8 bits held ", tag}, dec_bits, exp);
    endtask

    initial begin
        logic [N-1:0] exp_v;
        repeat (3) @(negedge clk);
        check(busy === 1'b0 && done === 1'b0, "R2 reset handshake", {busy, done}, 0);
        check(dec_bits === '0, "R8 reset bits", dec_bits, 0);
        rst_n = 1'b1;

        // R4: no cross terms, decisions are plain signs; zero maps to bit 0.
        clear_case();
        st = '{100, -5, 0, -2048, 2047, -1, 1, 0};
        load_stats(); load_rows();
        run_check("signs", 8'b0010_1010, 1'b0);

        // R3: order matters; user 0 (|100|) before user 1 (|90|).
        clear_case();
        st[0] = 100; st[1] = -90; rm[0][1] = 200; rm[1][0] = -300;
        load_stats(); load_rows();
        run_check("order", 8'b0000_0010, 1'b0);

        // R3: equal magnitudes resolve the lower index first.
        clear_case();
        st[0] = 50; st[1] = -50; rm[0][1] = 100; rm[1][0] = -100;
        load_stats(); load_rows();
        run_check("tie", 8'b0000_0010, 1'b0);

        // R5: first cycle cancels nothing; bit 1 adds the coefficient.
        clear_case();
        st[0] = -600; st[2] = 300; rm[0][2] = 500;
        load_stats(); load_rows();
        run_check("add_mode", 8'b0000_0001, 1'b0);

        // R6: saturation both ways; wrapping would flip users 1 and 2.
        clear_case();
        st[0] = 2047; st[1] = 2000; st[2] = -2000;
        rm[0][1] = -2048; rm[0][2] = 2047;
        load_stats(); load_rows();
        exp_v = model();
        check(exp_v[2:1] == 2'b10, "R6 model saturation", exp_v[2:1], 2'b10);
        run_check("saturate", exp_v, 1'b0);

        // R1 R7: writes and start during busy ignored; matrix persists.
        for (int t = 0; t < 6; t++) begin
            clear_case();
            for (int i = 0; i < N; i++) begin
                st[i] = int'($urandom_range(1200)) - 600;
                for (int k = 0; k < N; k++) rm[i][k] = int'($urandom_range(800)) - 400;
            end
            exp_v = model();
            load_stats(); load_rows();
            run_check("R1 junk while busy", exp_v, 1'b1);
            load_stats();
            run_check("R1 matrix kept", exp_v, 1'b0);
        end

        // Random sweep: full range and a narrow range that forces ties.
        for (int t = 0; t < 300; t++) begin
            int span = (t % 2 == 0) ? 4095 : 8;
            for (int i = 0; i < N; i++) begin
                st[i] = int'($urandom_range(span)) - (span + 1) / 2;
                for (int k = 0; k < N; k++) rm[i][k] = int'($urandom_range(span)) - (span + 1) / 2;
            end
            exp_v = model();
            load_stats(); load_rows();
            run_check("sweep R3 R5 R6 R7", exp_v, 1'b0);
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule